// File: doc/BRIEF.md
# USB Endpoint Register Write Arbiter

This block owns the small set of registers that a low-speed USB device controller shares between its CPU and its serial interface engine: the endpoint 0 mode register and three per-endpoint count/toggle registers. It decides, cycle by cycle, whose write lands. Updates that the serial engine makes at the end of a transaction always win. Once such an update has changed a register, that register refuses CPU writes until the CPU has read it, so firmware cannot overwrite status it has not yet seen. A write that is refused is dropped without any error. Firmware finds out by reading the register back and seeing the engine's value.

The block also tracks a setup flag. The flag is forced high from the start of a setup data phase until the engine begins its ACK. After that, the CPU cannot clear the flag until it has read the mode register. While the flag is high, CPU writes into two buffer address windows are suppressed, so a setup packet that is landing there cannot be corrupted by firmware filling an IN buffer. The CPU port is a plain strobe interface with no back-pressure: `io_wr` and `io_rd` are single-cycle pulses that are either accepted or dropped. `io_rdata` always shows the register at `io_addr` combinationally. Only a cycle with `io_rd` high has side effects.

Top module: `usb_ep_lock_arb`

## Requirements
- R1: After reset, the mode register and all count registers read 0x00 and no register is write-locked.
- R2: The mode register is at address 0x12 and the count registers are at 0x11, 0x13 and 0x15 (endpoints 0, 1, 2). Mode layout: [7] setup flag, [6] IN done, [5] OUT done, [4] ack, [3:0] mode code. Count layout: [7] toggle (1 = DATA1), [6] data valid, [5:4] reserved and read 0, [3:0] byte count. `io_rdata` shows the addressed register in the same cycle, and any other address reads 0x00.
- R3: From the cycle after `sie_setup_start` until `sie_ack_start`, the setup flag reads 1, and a CPU write of 0 to bit 7 leaves it at 1.
- R4: After `sie_ack_start`, the setup flag still cannot be cleared by the CPU until the CPU has read the mode register (a read pulse at 0x12 while the force window is closed). After that read, a CPU write to bit 7 takes effect.
- R5: When `sie_done` is high with `sie_acked`, the engine sets the ack bit, and also sets IN done when `sie_kind` = 2 or OUT done when `sie_kind` = 1 (0 = setup). A `sie_done` without `sie_acked` leaves the mode register unchanged.
- R6: An engine update locks the mode register only if it changed one of bits [6:0]. While the register is locked, CPU writes to it are dropped. A read pulse at 0x12 unlocks it.
- R7: If an engine update and a CPU write to the mode register arrive in the same cycle, the engine value is stored, the CPU data is discarded and the lock is set.
- R8: On `sie_done` with `sie_kind` setup or OUT, the count register selected by `sie_ep` takes the byte count, data valid = `sie_crc_ok` and toggle = `sie_rx_toggle`. It locks only if its value changed, and a read pulse at its own address unlocks it. An IN transaction and the other count registers are not affected.
- R9: A CPU write to an unlocked count register stores bits 7 and 6, reads bits 5:4 as 0, and saturates a byte count above 8 to 8.
- R10: `buf_wr` follows `io_wr` for addresses 0xE0–0xFF, except that it is held low for 0xE0–0xE7 and 0xF8–0xFF while the setup flag is 1. It is never high for any other address.
- R11: A CPU write to an unlocked mode register stores bits [6:0] as written, and stores bit 7 as written when no setup guard is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | CPU I/O address |
| io_wr | input | 1 | CPU write pulse |
| io_rd | input | 1 | CPU read pulse (unlocks the addressed register) |
| io_wdata | input | 8 | CPU write data |
| io_rdata | output | 8 | Addressed register value |
| buf_wr | output | 1 | Gated write enable to the endpoint buffer memory |
| sie_setup_start | input | 1 | Engine: setup data phase begins |
| sie_ack_start | input | 1 | Engine: ACK packet begins |
| sie_done | input | 1 | Engine: transaction finished |
| sie_acked | input | 1 | Finished transaction ended with ACK |
| sie_kind | input | 2 | Token kind: 0 setup, 1 OUT, 2 IN |
| sie_ep | input | 2 | Endpoint of the finished transaction |
| sie_rx_count | input | 4 | Received byte count |
| sie_rx_toggle | input | 1 | Received data toggle |
| sie_crc_ok | input | 1 | Received packet passed CRC |

## Verification
The bench sweeps every address with the setup flag both low and high, and compares `buf_wr` against the window arithmetic. A wrong window edge would let firmware corrupt a landing setup packet, or would block a legal buffer write. It also writes all 256 values into each count register, so a design that forgets to saturate or leaks the reserved bits shows up at once. Transactions that change nothing must leave the registers unlocked. A design that locks on every update would silently drop the next firmware write. A CPU write in the same cycle as an engine update must lose. The setup flag must stay high after the ACK until a read. A design that releases it at the ACK would reopen the buffer windows too early.

// File: rtl/usb_lock_pkg.sv
package usb_lock_pkg;
  localparam int DW = 8;
  localparam int CNT_W = 4;
  localparam int MB_SETUP = 7;
  localparam int MB_IN = 6;
  localparam int MB_OUT = 5;
  localparam int MB_ACK = 4;
  localparam int CB_TOG = 7;
  localparam int CB_VALID = 6;
  localparam logic [CNT_W-1:0] MAX_COUNT = 4'd8;

  typedef enum logic [1:0] {
    XK_SETUP = 2'd0,
    XK_OUT   = 2'd1,
    XK_IN    = 2'd2,
    XK_NONE  = 2'd3
  } xact_kind_e;

  function automatic logic [CNT_W-1:0] sat_count(input logic [CNT_W-1:0] c);
    return (c > MAX_COUNT) ? MAX_COUNT : c;
  endfunction
endpackage

// File: rtl/lock_mode_reg.sv
module lock_mode_reg
  import usb_lock_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          sie_setup_start,
  input  logic          sie_ack_start,
  input  logic          sie_upd,
  input  logic [1:0]    sie_kind,
  output logic [DW-1:0] mode_q,
  output logic          locked
);
  logic [DW-1:0] mode_r, mode_n, sie_img;
  logic lock_r, force_r, hold_r;
  logic sie_chg, cpu_ok, flag_guard;

  always_comb begin
    sie_img = mode_r;
    sie_img[MB_ACK] = 1'b1;
    case (xact_kind_e'(sie_kind))
      XK_IN:   sie_img[MB_IN]  = 1'b1;
      XK_OUT:  sie_img[MB_OUT] = 1'b1;
      default: ;
    endcase
  end

  assign sie_chg    = sie_upd && (sie_img[DW-2:0] != mode_r[DW-2:0]);
  assign cpu_ok     = cpu_wr && !lock_r && !sie_upd;
  assign flag_guard = force_r || hold_r || sie_setup_start;

  always_comb begin
    mode_n = mode_r;
    if (sie_upd) begin
      mode_n[DW-2:0] = sie_img[DW-2:0];
    end else if (cpu_ok) begin
      mode_n[DW-2:0] = cpu_wdata[DW-2:0];
      if (!flag_guard) mode_n[MB_SETUP] = cpu_wdata[MB_SETUP];
    end
    if (sie_setup_start) mode_n[MB_SETUP] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r  <= '0;
      lock_r  <= 1'b0;
      force_r <= 1'b0;
      hold_r  <= 1'b0;
    end else begin
      mode_r <= mode_n;
      if (sie_chg)     lock_r <= 1'b1;
      else if (cpu_rd) lock_r <= 1'b0;
      if (sie_setup_start)    force_r <= 1'b1;
      else if (sie_ack_start) force_r <= 1'b0;
      if (sie_setup_start)          hold_r <= 1'b1;
      else if (cpu_rd && !force_r)  hold_r <= 1'b0;
    end
  end

  assign mode_q = mode_r;
  assign locked = lock_r;
endmodule

// File: rtl/lock_count_reg.sv
module lock_count_reg
  import usb_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic             sie_wr,
  input  logic [CNT_W-1:0] sie_count,
  input  logic             sie_valid,
  input  logic             sie_toggle,
  output logic [DW-1:0]    cnt_q,
  output logic             locked
);
  logic [DW-1:0] cnt_r, cpu_img, sie_img;
  logic lock_r, sie_chg;

  always_comb begin
    cpu_img = '0;
    cpu_img[CB_TOG]      = cpu_wdata[CB_TOG];
    cpu_img[CB_VALID]    = cpu_wdata[CB_VALID];
    cpu_img[CNT_W-1:0]   = sat_count(cpu_wdata[CNT_W-1:0]);
    sie_img = '0;
    sie_img[CB_TOG]      = sie_toggle;
    sie_img[CB_VALID]    = sie_valid;
    sie_img[CNT_W-1:0]   = sat_count(sie_count);
  end

  assign sie_chg = sie_wr && (sie_img != cnt_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_r  <= '0;
      lock_r <= 1'b0;
    end else begin
      if (sie_wr)                 cnt_r <= sie_img;
      else if (cpu_wr && !lock_r) cnt_r <= cpu_img;
      if (sie_chg)     lock_r <= 1'b1;
      else if (cpu_rd) lock_r <= 1'b0;
    end
  end

  assign cnt_q  = cnt_r;
  assign locked = lock_r;
endmodule

// File: rtl/buf_guard.sv
module buf_guard #(
  parameter int AW = 8,
  parameter logic [AW-1:0] BUF_LO   = 8'hE0,
  parameter logic [AW-1:0] BUF_HI   = 8'hFF,
  parameter logic [AW-1:0] WIN_A_HI = 8'hE7,
  parameter logic [AW-1:0] WIN_B_LO = 8'hF8
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          setup_flag,
  output logic          buf_wr
);
  logic in_buf, in_win;
  assign in_buf = (addr >= BUF_LO) && (addr <= BUF_HI);
  assign in_win = in_buf && ((addr <= WIN_A_HI) || (addr >= WIN_B_LO));
  assign buf_wr = wr && in_buf && !(setup_flag && in_win);
endmodule

// File: rtl/usb_ep_lock_arb.sv
module usb_ep_lock_arb
  import usb_lock_pkg::*;
#(
  parameter int NUM_CNT = 3,
  parameter logic [7:0] CNT_BASE   = 8'h11,
  parameter logic [7:0] CNT_STRIDE = 8'h02,
  parameter logic [7:0] MODE_ADDR  = 8'h12,
  localparam int EP_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      io_addr,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [DW-1:0]   io_wdata,
  output logic [DW-1:0]   io_rdata,
  output logic            buf_wr,
  input  logic            sie_setup_start,
  input  logic            sie_ack_start,
  input  logic            sie_done,
  input  logic            sie_acked,
  input  logic [1:0]      sie_kind,
  input  logic [EP_W-1:0] sie_ep,
  input  logic [CNT_W-1:0] sie_rx_count,
  input  logic            sie_rx_toggle,
  input  logic            sie_crc_ok
);
  logic [DW-1:0] mode_q;
  logic mode_lock, mode_hit;
  logic [NUM_CNT-1:0][DW-1:0] cnt_q;
  logic [NUM_CNT-1:0] cnt_lock, cnt_hit;
  logic rx_kind;

  assign mode_hit = (io_addr == MODE_ADDR);
  assign rx_kind  = (xact_kind_e'(sie_kind) == XK_OUT) || (xact_kind_e'(sie_kind) == XK_SETUP);

  lock_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr(io_wr && mode_hit), .cpu_rd(io_rd && mode_hit), .cpu_wdata(io_wdata),
    .sie_setup_start(sie_setup_start), .sie_ack_start(sie_ack_start),
    .sie_upd(sie_done && sie_acked), .sie_kind(sie_kind),
    .mode_q(mode_q), .locked(mode_lock)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [7:0] ADDR_I = CNT_BASE + 8'(i) * CNT_STRIDE;
    assign cnt_hit[i] = (io_addr == ADDR_I);
    lock_count_reg u_cnt (
      .clk(clk), .rst_n(rst_n),
      .cpu_wr(io_wr && cnt_hit[i]), .cpu_rd(io_rd && cnt_hit[i]), .cpu_wdata(io_wdata),
      .sie_wr(sie_done && rx_kind && (sie_ep == EP_W'(i))),
      .sie_count(sie_rx_count), .sie_valid(sie_crc_ok), .sie_toggle(sie_rx_toggle),
      .cnt_q(cnt_q[i]), .locked(cnt_lock[i])
    );
  end

  always_comb begin
    io_rdata = '0;
    if (mode_hit) io_rdata = mode_q;
    for (int i = 0; i < NUM_CNT; i++)
      if (cnt_hit[i]) io_rdata = cnt_q[i];
  end

  buf_guard #(.AW(8)) u_guard (
    .addr(io_addr), .wr(io_wr), .setup_flag(mode_q[MB_SETUP]), .buf_wr(buf_wr)
  );
endmodule

// File: rtl/usb_ep_lock_arb_chk.sv
module usb_ep_lock_arb_chk #(
  parameter int NUM_CNT = 3,
  parameter logic [7:0] MODE_ADDR = 8'h12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [7:0]                 io_addr,
  input logic                       io_wr,
  input logic                       io_rd,
  input logic                       sie_setup_start,
  input logic                       sie_done,
  input logic                       sie_acked,
  input logic [7:0]                 mode_q,
  input logic                       mode_lock,
  input logic [NUM_CNT-1:0][7:0]    cnt_q
);
  p_setup_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sie_setup_start |=> mode_q[7]);

  p_locked_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lock && io_wr && io_addr == MODE_ADDR && !sie_done && !sie_setup_start)
      |=> $stable(mode_q));

  p_read_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == MODE_ADDR && !(sie_done && sie_acked)) |=> !mode_lock);

  p_ack_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_done && sie_acked) |=> mode_q[4]);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    p_count_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i][3:0] <= 4'd8) && (cnt_q[i][5:4] == 2'b00));
  end
endmodule

bind usb_ep_lock_arb usb_ep_lock_arb_chk #(.NUM_CNT(NUM_CNT), .MODE_ADDR(MODE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .sie_setup_start(sie_setup_start), .sie_done(sie_done), .sie_acked(sie_acked),
  .mode_q(mode_q), .mode_lock(mode_lock), .cnt_q(cnt_q)
);

// File: tb/usb_ep_lock_arb_bench.sv
`timescale 1ns/1ps
module usb_ep_lock_arb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_rdata;
  logic buf_wr;
  logic sie_setup_start = 1'b0, sie_ack_start = 1'b0, sie_done = 1'b0, sie_acked = 1'b0;
  logic [1:0] sie_kind = '0, sie_ep = '0;
  logic [3:0] sie_rx_count = '0;
  logic sie_rx_toggle = 1'b0, sie_crc_ok = 1'b0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  usb_ep_lock_arb u_usb_ep_lock_arb (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .buf_wr(buf_wr),
    .sie_setup_start(sie_setup_start), .sie_ack_start(sie_ack_start),
    .sie_done(sie_done), .sie_acked(sie_acked), .sie_kind(sie_kind), .sie_ep(sie_ep),
    .sie_rx_count(sie_rx_count), .sie_rx_toggle(sie_rx_toggle), .sie_crc_ok(sie_crc_ok)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1; #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic peek(input string req, input logic [7:0] a, input logic [7:0] exp);
    io_addr = a; #1 chk(req, io_rdata, exp);
  endtask

  task automatic sie_end(input logic [1:0] k, input logic ack, input logic [1:0] ep,
                         input logic [3:0] c, input logic tog, input logic crc);
    @(negedge clk);
    sie_done = 1'b1; sie_acked = ack; sie_kind = k; sie_ep = ep;
    sie_rx_count = c; sie_rx_toggle = tog; sie_crc_ok = crc;
    @(negedge clk); sie_done = 1'b0; sie_acked = 1'b0;
  endtask

  task automatic buf_sweep(input logic setup, input string req);
    for (int a = 0; a < 256; a++) begin
      logic exp;
      io_addr = 8'(a); io_wr = 1'b1; #1;
      exp = (a >= 8'hE0) && !(setup && (a <= 8'hE7 || a >= 8'hF8));
      chk(req, {7'd0, buf_wr}, {7'd0, exp});
      io_wr = 1'b0; #1;
    end
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek("R1 mode", 8'h12, 8'h00);
    peek("R1 cnt0", 8'h11, 8'h00);
    peek("R1 cnt1", 8'h13, 8'h00);
    peek("R1 cnt2", 8'h15, 8'h00);
    peek("R2 unmapped", 8'h14, 8'h00);
    buf_sweep(1'b0, "R10 idle");

    // R9 count write sweep on each register
    for (int r = 0; r < 3; r++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] d, e;
        d = 8'(v);
        e = {d[7], d[6], 2'b00, (d[3:0] > 4'd8) ? 4'd8 : d[3:0]};
        cpu_write(8'h11 + 8'(2*r), d);
        peek("R9 count write", 8'h11 + 8'(2*r), e);
      end
    end

    // R11 plain mode writes
    cpu_write(8'h12, 8'h05); peek("R11 mode", 8'h12, 8'h05);
    cpu_write(8'h12, 8'h83); peek("R11 mode bit7", 8'h12, 8'h83);
    cpu_write(8'h12, 8'h00); peek("R11 clear", 8'h12, 8'h00);

    // R5 / R6 lock behaviour
    cpu_write(8'h12, 8'h03);
    sie_end(2'd2, 1'b1, 2'd0, 4'd0, 1'b0, 1'b0);
    peek("R5 IN acked", 8'h12, 8'h53);
    cpu_write(8'h12, 8'h00); peek("R6 locked drop", 8'h12, 8'h53);
    cpu_read(8'h12, rd); chk("R6 read value", rd, 8'h53);
    cpu_write(8'h12, 8'h01); peek("R6 unlocked", 8'h12, 8'h01);
    sie_end(2'd1, 1'b0, 2'd3, 4'd0, 1'b0, 1'b0);
    peek("R5 no ack", 8'h12, 8'h01);
    cpu_write(8'h12, 8'h02); peek("R6 no lock w/o ack", 8'h12, 8'h02);
    sie_end(2'd1, 1'b1, 2'd3, 4'd0, 1'b0, 1'b0);
    peek("R5 OUT acked", 8'h12, 8'h32);
    cpu_read(8'h12, rd);
    sie_end(2'd1, 1'b1, 2'd3, 4'd0, 1'b0, 1'b0);
    cpu_write(8'h12, 8'h04); peek("R6 unchanged no lock", 8'h12, 8'h04);

    // R7 same-cycle collision
    @(negedge clk);
    io_addr = 8'h12; io_wdata = 8'h09; io_wr = 1'b1;
    sie_done = 1'b1; sie_acked = 1'b1; sie_kind = 2'd2; sie_ep = 2'd3;
    @(negedge clk); io_wr = 1'b0; sie_done = 1'b0; sie_acked = 1'b0;
    peek("R7 sie wins", 8'h12, 8'h54);
    cpu_write(8'h12, 8'h00); peek("R7 lock set", 8'h12, 8'h54);
    cpu_read(8'h12, rd);

    // R3 / R4 setup flag
    cpu_write(8'h12, 8'h00); peek("R11 zero", 8'h12, 8'h00);
    @(negedge clk); sie_setup_start = 1'b1;
    @(negedge clk); sie_setup_start = 1'b0;
    peek("R3 forced", 8'h12, 8'h80);
    cpu_write(8'h12, 8'h00); peek("R3 no clear", 8'h12, 8'h80);
    buf_sweep(1'b1, "R10 setup");
    cpu_read(8'h12, rd); chk("R3 read during force", rd, 8'h80);
    @(negedge clk); sie_ack_start = 1'b1;
    @(negedge clk); sie_ack_start = 1'b0;
    cpu_write(8'h12, 8'h00); peek("R4 held after ack", 8'h12, 8'h80);
    sie_end(2'd0, 1'b1, 2'd0, 4'd8, 1'b0, 1'b1);
    peek("R5 setup acked", 8'h12, 8'h90);
    peek("R8 setup count", 8'h11, 8'h48);
    cpu_read(8'h12, rd); chk("R4 read", rd, 8'h90);
    cpu_write(8'h12, 8'h00); peek("R4 cleared", 8'h12, 8'h00);
    buf_sweep(1'b0, "R10 after clear");

    // R8 count register engine writes
    sie_end(2'd1, 1'b1, 2'd1, 4'd5, 1'b1, 1'b1);
    peek("R8 OUT ep1", 8'h13, 8'hC5);
    cpu_write(8'h13, 8'h00); peek("R8 cnt locked", 8'h13, 8'hC5);
    cpu_write(8'h15, 8'h03); peek("R8 other free", 8'h15, 8'h03);
    cpu_read(8'h13, rd); chk("R8 read", rd, 8'hC5);
    cpu_write(8'h13, 8'h02); peek("R8 unlocked", 8'h13, 8'h02);
    sie_end(2'd1, 1'b0, 2'd2, 4'd8, 1'b0, 1'b0);
    peek("R8 bad crc", 8'h15, 8'h08);
    sie_end(2'd2, 1'b1, 2'd1, 4'd7, 1'b1, 1'b1);
    peek("R8 IN ignored", 8'h13, 8'h02);
    peek("R2 unmapped 0x10", 8'h10, 8'h00);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule